// File: doc/BRIEF.md
# Conversion Start and Result Controller for a Successive-Approximation ADC

This block is the digital half of a successive-approximation converter. Software programs a control word that picks a channel, a resolution and a start source. A conversion can begin right away on a software command, on a chosen edge of one of six external trigger lines, or repeatedly in a free-running burst mode. While a conversion is in progress, the block counts converter clocks and shifts in one comparator decision per clock, most significant bit first. When the last clock ends, it loads the result into a data register with a completion flag, a lost-result flag and the channel number.

The analog front end is not part of the block. It is represented by a single comparator input bit that the surrounding logic, or a testbench, drives once per clock while a conversion is active. Fewer clocks per conversion give a shorter conversion and a coarser result, and the coarse result always sits in the low bits of the result field.

Top module: `adc_trig_ctrl`

## Requirements
- R1: Resolution code `k` (control bits [9:7]) gives a conversion that keeps `conv_active` high for exactly `11-k` clock cycles and yields `10-k` result bits: 11 cycles for code 0 and 4 cycles for code 7. Code and channel are latched when the conversion starts.
- R2: The result field (`dr_rdata[9:0]`) holds the comparator bits sampled in the first `10-k` active cycles. The first sample becomes the most significant valid bit, the valid bits sit in the low positions, and all higher bits read 0.
- R3: Writing start code 1 (control bits [5:3]) with power on and burst off begins exactly one conversion. `conv_active` rises in the second cycle after the write, and no further conversion follows while the code stays 1.
- R4: Start codes 2 to 7 select trigger input `code-2`. Edges on the other trigger inputs start nothing. Start code 0 starts nothing.
- R5: Polarity bit (control bit 6) = 0 starts a conversion on a rising edge of the selected trigger, and 1 starts it on a falling edge. An edge of the opposite direction starts nothing.
- R6: Trigger inputs pass through two synchronizing flops and one history flop. `conv_active` rises on the third rising clock edge after the trigger changes.
- R7: With burst (control bit 10) set and power on, conversions repeat back to back with one idle cycle between them, whatever the start code. Clearing burst stops new conversions.
- R8: Power bit (control bit 11) = 0 is power-down. No conversion starts, and an active conversion is abandoned within two cycles of the write without setting DONE.
- R9: DONE (`dr_rdata[14]`) sets when a conversion completes. A one-cycle `dr_rd` pulse clears it, and the data sampled during that pulse show the value from before the clear.
- R10: OVERRUN (`dr_rdata[13]`) sets when a result completes while DONE is still set and no read is in progress. It stays set until the next read, and the newer result replaces the older one.
- R11: A start request that arrives during an active conversion is dropped. It neither lengthens the conversion nor starts a later one.
- R12: Control bits [15:12] are reserved. Ones written there change nothing.
- R13: `dr_rdata[12:10]` carries the channel (control bits [2:0]) that was selected when the conversion started.
- R14: After reset, `dr_rdata` is 0, `conv_active` is 0 and the converter is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word: channel, start code, polarity, resolution, burst, power |
| trig_in | input | 6 | External start trigger lines, asynchronous |
| cmp_bit | input | 1 | Comparator decision from the converter stub |
| dr_rd | input | 1 | Data register read strobe, clears DONE and OVERRUN |
| dr_rdata | output | 16 | Result, channel, OVERRUN and DONE |
| conv_active | output | 1 | High while a conversion runs |

## Verification
The hardest condition to reach from the ports is a start request that lands in the middle of a running conversion. A trigger edge or software write at a random time almost always finds the converter idle. The bench therefore counts active cycles as it observes them and issues a second software start on the second active cycle of a seven-cycle conversion. It then checks both the conversion length and the quiet period that follows. An overrun is reached in the same deliberate way: two conversions are completed back to back with the read strobe held off, and power-down abort is timed to land in the middle of the longest conversion.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam int CODE_W      = 3;
  localparam int DEF_RES_MAX = 10;
  localparam int DEF_CHAN_W  = 3;
  localparam int DEF_N_TRIG  = 6;
  localparam int DEF_CTL_W   = 16;

  localparam logic [CODE_W-1:0] START_NONE  = 3'd0;
  localparam logic [CODE_W-1:0] START_NOW   = 3'd1;
  localparam int                START_TRIG0 = 2;

  // number of result bits for a resolution code
  function automatic int res_bits(input int res_max, input logic [CODE_W-1:0] code);
    return res_max - int'(code);
  endfunction

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int N_TRIG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  output logic [N_TRIG-1:0] rise,
  output logic [N_TRIG-1:0] fall
);

  for (genvar i = 0; i < N_TRIG; i++) begin : g_line
    logic meta_q, sync_q, hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        hist_q <= 1'b0;
      end else begin
        meta_q <= trig_in[i];
        sync_q <= meta_q;
        hist_q <= sync_q;
      end
    end

    assign rise[i] = sync_q & ~hist_q;
    assign fall[i] = ~sync_q & hist_q;
  end

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
  parameter int RES_MAX = 10,
  parameter int CHAN_W  = 3,
  parameter int CODE_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               start,
  input  logic [CODE_W-1:0]  code,
  input  logic [CHAN_W-1:0]  chan,
  input  logic               cmp_bit,
  output logic               busy,
  output logic               done_pulse,
  output logic [RES_MAX-1:0] result,
  output logic [CHAN_W-1:0]  res_chan,
  output logic [CODE_W-1:0]  act_code
);

  localparam int CNT_W = $clog2(RES_MAX + 1);

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CODE_W-1:0]  code_q, code_d;
  logic [CHAN_W-1:0]  chan_q, chan_d;
  logic [RES_MAX-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   bits_w;
  logic               last_w;

  always_comb begin
    bits_w = CNT_W'(RES_MAX - int'(code_q));
    last_w = (cnt_q == bits_w);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    code_d = code_q;
    chan_d = chan_q;
    sr_d   = sr_q;
    if (!run) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (last_w) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
        sr_d  = {sr_q[RES_MAX-2:0], cmp_bit};
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      sr_d   = '0;
      code_d = code;
      chan_d = chan;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      code_q <= '0;
      chan_q <= '0;
      sr_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      code_q <= code_d;
      chan_q <= chan_d;
      sr_q   <= sr_d;
    end
  end

  assign busy       = busy_q;
  assign done_pulse = busy_q & run & last_w;
  assign result     = sr_q;
  assign res_chan   = chan_q;
  assign act_code   = code_q;

endmodule

// File: rtl/adc_trig_dreg.sv
module adc_trig_dreg #(
  parameter int RES_MAX = 10,
  parameter int CHAN_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [RES_MAX-1:0] ld_res,
  input  logic [CHAN_W-1:0]  ld_chan,
  input  logic               rd,
  output logic [RES_MAX-1:0] res_q,
  output logic [CHAN_W-1:0]  chan_q,
  output logic               done_q,
  output logic               ovr_q
);

  logic [RES_MAX-1:0] res_d;
  logic [CHAN_W-1:0]  chan_d;
  logic               done_d, ovr_d;

  always_comb begin
    res_d  = res_q;
    chan_d = chan_q;
    done_d = done_q;
    ovr_d  = ovr_q;
    if (load) begin
      res_d  = ld_res;
      chan_d = ld_chan;
      done_d = 1'b1;
      ovr_d  = done_q & ~rd;
    end else if (rd) begin
      done_d = 1'b0;
      ovr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      chan_q <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      chan_q <= chan_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
    end
  end

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int N_TRIG  = DEF_N_TRIG,
  parameter int RES_MAX = DEF_RES_MAX,
  parameter int CHAN_W  = DEF_CHAN_W,
  parameter int CTL_W   = DEF_CTL_W,
  localparam int DR_W   = RES_MAX + CHAN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic              cmp_bit,
  input  logic              dr_rd,
  output logic [DR_W-1:0]   dr_rdata,
  output logic              conv_active
);

  // control word layout
  localparam int CH_LO    = 0;
  localparam int ST_LO    = CH_LO + CHAN_W;
  localparam int FL_B     = ST_LO + CODE_W;
  localparam int CK_LO    = FL_B + 1;
  localparam int BU_B     = CK_LO + CODE_W;
  localparam int RU_B     = BU_B + 1;
  localparam int CTL_USED = RU_B + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  // control register
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [CODE_W-1:0] start_q, start_d;
  logic [CODE_W-1:0] clk_q, clk_d;
  logic              fall_q, fall_d;
  logic              burst_q, burst_d;
  logic              run_q, run_d;
  logic              sw_q, sw_d;
  logic              unused_rsv;

  assign unused_rsv = ^ctl_wdata[CTL_W-1:CTL_USED];

  always_comb begin
    chan_d  = chan_q;
    start_d = start_q;
    clk_d   = clk_q;
    fall_d  = fall_q;
    burst_d = burst_q;
    run_d   = run_q;
    sw_d    = 1'b0;
    if (ctl_wr) begin
      chan_d  = ctl_wdata[CH_LO +: CHAN_W];
      start_d = ctl_wdata[ST_LO +: CODE_W];
      clk_d   = ctl_wdata[CK_LO +: CODE_W];
      fall_d  = ctl_wdata[FL_B];
      burst_d = ctl_wdata[BU_B];
      run_d   = ctl_wdata[RU_B];
      sw_d    = (ctl_wdata[ST_LO +: CODE_W] == START_NOW) & ~ctl_wdata[BU_B] & ctl_wdata[RU_B];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      chan_q  <= '0;
      start_q <= START_NONE;
      clk_q   <= '0;
      fall_q  <= 1'b0;
      burst_q <= 1'b0;
      run_q   <= 1'b0;
      sw_q    <= 1'b0;
    end else begin
      chan_q  <= chan_d;
      start_q <= start_d;
      clk_q   <= clk_d;
      fall_q  <= fall_d;
      burst_q <= burst_d;
      run_q   <= run_d;
      sw_q    <= sw_d;
    end
  end

  // trigger edges and source selection
  logic [N_TRIG-1:0] rise_v, fall_v, hit_v;

  adc_trig_edge #(.N_TRIG(N_TRIG)) u_edge (
    .clk     (clk),
    .rst_n   (rst_i),
    .trig_in (trig_in),
    .rise    (rise_v),
    .fall    (fall_v)
  );

  for (genvar i = 0; i < N_TRIG; i++) begin : g_hit
    assign hit_v[i] = (start_q == CODE_W'(START_TRIG0 + i)) & (fall_q ? fall_v[i] : rise_v[i]);
  end

  logic start_w, seq_done;
  logic [RES_MAX-1:0] seq_res;
  logic [CHAN_W-1:0]  seq_chan;
  logic [CODE_W-1:0]  act_code;

  assign start_w = run_q & (burst_q ? ~conv_active : (sw_q | (|hit_v)));

  adc_trig_seq #(.RES_MAX(RES_MAX), .CHAN_W(CHAN_W), .CODE_W(CODE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_i),
    .run        (run_q),
    .start      (start_w),
    .code       (clk_q),
    .chan       (chan_q),
    .cmp_bit    (cmp_bit),
    .busy       (conv_active),
    .done_pulse (seq_done),
    .result     (seq_res),
    .res_chan   (seq_chan),
    .act_code   (act_code)
  );

  logic [RES_MAX-1:0] res_q;
  logic [CHAN_W-1:0]  rchan_q;
  logic               done_q, ovr_q;

  adc_trig_dreg #(.RES_MAX(RES_MAX), .CHAN_W(CHAN_W)) u_dreg (
    .clk     (clk),
    .rst_n   (rst_i),
    .load    (seq_done),
    .ld_res  (seq_res),
    .ld_chan (seq_chan),
    .rd      (dr_rd),
    .res_q   (res_q),
    .chan_q  (rchan_q),
    .done_q  (done_q),
    .ovr_q   (ovr_q)
  );

  assign dr_rdata = {1'b0, done_q, ovr_q, rchan_q, res_q};

endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk #(
  parameter int RES_MAX = 10,
  parameter int CODE_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              busy,
  input logic              done_pulse,
  input logic              done,
  input logic              ovr,
  input logic              rd,
  input logic [CODE_W-1:0] act_code
);

  localparam int LW = $clog2(RES_MAX + 2) + 1;

  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + LW'(1);
    else           len_q <= '0;
  end

  // R1: active cycles before completion match the latched resolution
  assert_conv_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (int'(len_q) == RES_MAX - int'(act_code)));

  // R8: powered down means no conversion on the next cycle
  assert_pdn_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !busy);

  // R9: DONE only rises right after an active cycle
  assert_done_after_conv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R9: a read without a simultaneous completion clears both flags
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done_pulse) |=> (!done && !ovr));

  // R10: overrun requires an unread earlier result
  assert_ovr_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(done));

endmodule

bind adc_trig_ctrl adc_trig_chk #(.RES_MAX(RES_MAX), .CODE_W(adc_trig_pkg::CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run_q),
  .busy       (conv_active),
  .done_pulse (seq_done),
  .done       (done_q),
  .ovr        (ovr_q),
  .rd         (dr_rd),
  .act_code   (act_code)
);

// File: tb/adc_trig_ctrl_test.sv
module adc_trig_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr;
  logic [15:0] ctl_wdata;
  logic [5:0]  trig;
  logic        cmp_bit;
  logic        dr_rd;
  logic [15:0] dr_rdata;
  logic        conv_active;

  int n_chk = 0;
  int n_fail = 0;
  logic [9:0] pat;
  int cur_bits = 10;
  int act_k = 0;

  adc_trig_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .trig_in     (trig),
    .cmp_bit     (cmp_bit),
    .dr_rd       (dr_rd),
    .dr_rdata    (dr_rdata),
    .conv_active (conv_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator stub: MSB of the pattern first while a conversion runs
  always @(negedge clk) begin
    if (conv_active) begin
      if (act_k < cur_bits) cmp_bit = pat[cur_bits-1-act_k];
      else                  cmp_bit = 1'b1;
      act_k++;
    end else begin
      act_k   = 0;
      cmp_bit = 1'b1;
    end
  end

  function automatic int exp_res(input logic [9:0] p, input int bits);
    return int'(p) & ((1 << bits) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ch, input logic [2:0] st, input bit fl,
                    input logic [2:0] ck, input bit bu, input bit ru, input logic [3:0] rsv);
    @(negedge clk);
    ctl_wdata = {rsv, ru, bu, ck, fl, st, ch};
    ctl_wr    = 1'b1;
    @(negedge clk);
    ctl_wr    = 1'b0;
  endtask

  task automatic wait_conv(output int t, output int len);
    t = 0;
    len = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!conv_active && t < 40);
    while (conv_active && len < 40) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, output bit seen);
    seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (conv_active) seen = 1'b1;
    end
  endtask

  task automatic rd(output logic [15:0] v);
    v = dr_rdata;
    dr_rd = 1'b1;
    @(negedge clk);
    dr_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t, len, code, ch, ti, cnt, g;
    bit fl, seen;
    logic [15:0] v;

    void'($urandom(32'h1a2b3c));
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; trig = '0; dr_rd = 1'b0;
    pat = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(dr_rdata == 16'h0 && !conv_active, "R14 reset state", int'(dr_rdata), 0);

    // constrained random conversions
    for (int it = 0; it < 24; it++) begin
      code = $urandom_range(0, 7);
      ch   = $urandom_range(0, 7);
      pat  = 10'($urandom);
      cur_bits = 10 - code;
      if ($urandom_range(0, 1) == 0) begin
        wr(3'(ch), 3'd1, 1'b0, 3'(code), 1'b0, 1'b1, 4'h0);
        wait_conv(t, len);
        chk(t == 1, "R3 software start latency", t, 1);
      end else begin
        ti = $urandom_range(0, 5);
        fl = 1'($urandom_range(0, 1));
        wr(3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 4'h0);
        trig = 6'($urandom);
        trig[ti] = fl;
        repeat (4) @(negedge clk);
        wr(3'(ch), 3'(2 + ti), fl, 3'(code), 1'b0, 1'b1, 4'h0);
        repeat (2) @(negedge clk);
        trig[ti] = ~fl;
        wait_conv(t, len);
        chk(t == 3, "R6 trigger to active latency (R4 R5 selected edge)", t, 3);
      end
      chk(len == cur_bits + 1, "R1 conversion length", len, cur_bits + 1);
      rd(v);
      chk(v[14] == 1'b1, "R9 done after conversion", int'(v[14]), 1);
      chk(int'(v[9:0]) == exp_res(pat, cur_bits), "R2 result aligned low", int'(v[9:0]), exp_res(pat, cur_bits));
      chk(int'(v[12:10]) == ch, "R13 channel number", int'(v[12:10]), ch);
      chk(v[13] == 1'b0, "R10 no overrun on single result", int'(v[13]), 0);
      chk(dr_rdata[14:13] == 2'b00, "R9 read clears done", int'(dr_rdata[14:13]), 0);
      if (it % 4 == 0) begin
        quiet(12, seen);
        chk(!seen, "R3 one conversion per write", int'(seen), 0);
      end
    end

    // R8 no start while powered down
    wr(3'd0, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0, 4'h0);
    quiet(15, seen);
    chk(!seen, "R8 powered down ignores start", int'(seen), 0);

    // R8 abort
    cur_bits = 10; pat = 10'h2a5;
    wr(3'd1, 3'd1, 1'b0, 3'd0, 1'b0, 1'b1, 4'h0);
    @(negedge clk);
    chk(conv_active, "R8 conversion under way before abort", int'(conv_active), 1);
    repeat (2) @(negedge clk);
    wr(3'd1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 4'h0);
    @(negedge clk);
    chk(!conv_active, "R8 power-down aborts", int'(conv_active), 0);
    quiet(15, seen);
    chk(dr_rdata[14] == 1'b0 && !seen, "R8 abort sets no done", int'(dr_rdata[14]), 0);

    // R11 start during conversion is dropped
    cur_bits = 6; pat = 10'h3c9;
    wr(3'd2, 3'd1, 1'b0, 3'd4, 1'b0, 1'b1, 4'h0);
    @(negedge clk);
    cnt = 0;
    while (conv_active && cnt < 40) begin
      cnt++;
      if (cnt == 2) begin
        ctl_wdata = {4'h0, 1'b1, 1'b0, 3'd4, 1'b0, 3'd1, 3'd2};
        ctl_wr = 1'b1;
      end
      if (cnt == 3) ctl_wr = 1'b0;
      @(negedge clk);
    end
    ctl_wr = 1'b0;
    chk(cnt == 7, "R11 length unchanged by mid start", cnt, 7);
    quiet(12, seen);
    chk(!seen, "R11 no deferred conversion", int'(seen), 0);
    rd(v);
    chk(int'(v[9:0]) == exp_res(pat, 6), "R11 result intact", int'(v[9:0]), exp_res(pat, 6));

    // R10 overrun
    cur_bits = 4; pat = 10'h00b;
    wr(3'd3, 3'd1, 1'b0, 3'd6, 1'b0, 1'b1, 4'h0);
    wait_conv(t, len);
    chk(dr_rdata[14:13] == 2'b10, "R10 first result, no overrun", int'(dr_rdata[14:13]), 2);
    pat = 10'h006;
    wr(3'd3, 3'd1, 1'b0, 3'd6, 1'b0, 1'b1, 4'h0);
    wait_conv(t, len);
    chk(dr_rdata[14:13] == 2'b11, "R10 overrun set", int'(dr_rdata[14:13]), 3);
    chk(int'(dr_rdata[9:0]) == 6, "R10 newer result kept", int'(dr_rdata[9:0]), 6);
    rd(v);
    chk(dr_rdata[14:13] == 2'b00, "R10 read clears overrun", int'(dr_rdata[14:13]), 0);

    // R4 / R5 trigger selection and polarity
    cur_bits = 3; pat = 10'h005;
    wr(3'd4, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 4'h0);
    trig = 6'b000100;
    repeat (4) @(negedge clk);
    wr(3'd4, 3'd4, 1'b0, 3'd7, 1'b0, 1'b1, 4'h0);
    repeat (2) @(negedge clk);
    trig[4] = 1'b1;
    quiet(8, seen);
    chk(!seen, "R4 unselected trigger ignored", int'(seen), 0);
    trig[2] = 1'b0;
    quiet(8, seen);
    chk(!seen, "R5 opposite edge ignored", int'(seen), 0);
    trig[2] = 1'b1;
    wait_conv(t, len);
    chk(t == 3, "R5 rising edge starts", t, 3);
    chk(len == 4, "R1 shortest conversion", len, 4);
    rd(v);
    chk(int'(v[9:0]) == 5, "R2 three-bit result", int'(v[9:0]), 5);

    // R7 burst
    cur_bits = 5; pat = 10'h019;
    wr(3'd5, 3'd1, 1'b0, 3'd5, 1'b1, 1'b1, 4'h0);
    wait_conv(t, len);
    chk(len == 6, "R7 burst conversion length", len, 6);
    chk(int'(dr_rdata[9:0]) == exp_res(pat, 5), "R7 burst result", int'(dr_rdata[9:0]), exp_res(pat, 5));
    g = 0;
    while (!conv_active && g < 10) begin
      g++;
      @(negedge clk);
    end
    chk(g == 1, "R7 one idle cycle between conversions", g, 1);
    len = 0;
    while (conv_active && len < 40) begin
      len++;
      @(negedge clk);
    end
    chk(len == 6, "R7 second burst conversion length", len, 6);
    wr(3'd5, 3'd0, 1'b0, 3'd5, 1'b0, 1'b1, 4'h0);
    g = 0;
    while (conv_active && g < 20) begin
      g++;
      @(negedge clk);
    end
    quiet(15, seen);
    chk(!seen, "R7 burst stops when cleared", int'(seen), 0);
    rd(v);

    // R12 reserved bits
    wr(3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 4'hf);
    quiet(12, seen);
    chk(!seen, "R12 reserved ones start nothing", int'(seen), 0);
    cur_bits = 7; pat = 10'h05e;
    wr(3'd6, 3'd1, 1'b0, 3'd3, 1'b0, 1'b1, 4'hf);
    wait_conv(t, len);
    chk(len == 8, "R12 reserved ones keep length", len, 8);
    rd(v);
    chk(int'(v[9:0]) == exp_res(pat, 7) && v[12:10] == 3'd6, "R12 reserved ones keep result",
        int'(v[12:0]), (6 << 10) | exp_res(pat, 7));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule